// File: doc/BRIEF.md
# Multi-Pattern BERT Pattern Generator

This block produces the transmit test bit stream for a per-channel bit-error-rate tester on a framed T1/E1 link. A 3-bit select picks one of several pattern families. These are four pseudorandom LFSR sequences, a zero-limited QRSS sequence, a programmable repetitive pattern 17 to 32 bits long, a counted alternating two-word pattern, and a fixed all-ones stand-in for the 55-octet pattern. Configuration takes effect only on a rising edge of a load control, and that edge also restarts the sequence from its seed.

A framer supplies a per-bit `bit_tick` and the number of the time slot that the bit belongs to. A 24-bit channel mask decides which slots take generator data. A slot that is masked off produces no output and leaves the pattern where it was. A single-error strobe arms a one-shot inversion of the next bit that is sent out, and an acknowledge pulse marks the corrupted bit.

Top module: `bert_patgen`

## Requirements
- R1: During and after reset, `tx_valid`, `tx_bit` and `err_ack` are 0. Until the first load, the generator runs PRBS 2^7-1 from an all-ones state.
- R2: Select codes 000, 111, 001 and 010 give PRBS of degree 7, 9, 11 and 15 with feedback polynomials x^7+x^6+1, x^9+x^5+1, x^11+x^9+1 and x^15+x^14+1. The LFSR is a Fibonacci register of degree n: each bit sent is bit n-1 of the state, and each step shifts the state left and enters bit n-1 XOR bit k-1, where k is the middle tap. On load, the state is seeded from the low n bits of `pat_word`, or with all ones if those bits are zero.
- R3: Select code 011 gives QRSS on x^20+x^17+1, with the same seeding rule. After 14 consecutive zero pattern bits, the next bit is forced to one, so no run of zeros exceeds 14.
- R4: Select code 100 sends `pat_word` LSB first, starting at bit 0, over a length of `len_code`+17 bits (0000 gives 17, 1111 gives 32). The sequence then wraps to bit 0.
- R5: Select code 101 sends `pat_word[15:0]` LSB first, repeated `alt_count` times (0 is treated as 1). It then sends `pat_word[31:16]` the same number of times, and alternates from there.
- R6: Select code 110 sends all ones.
- R7: The configuration inputs are captured and the sequence restarts only on a low-to-high edge of `load`. Changes to them at any other time have no effect. A slot that falls in the load-edge cycle produces no output.
- R8: A slot is enabled when `bit_tick` is 1, `chan_idx` is below 24 and `chan_mask[chan_idx]` is 1, where mask bit i belongs to channel i. A disabled slot produces no output and does not advance the pattern.
- R9: Each enabled slot gives `tx_valid`=1 with its `tx_bit` on the clock after the slot is presented, for one cycle. When `tx_valid` is 0, `tx_bit` is 0.
- R10: A rising edge of `err_strobe` arms an insertion. The next enabled bit is sent inverted and the insertion is disarmed. Several edges before that bit insert only one error.
- R11: `err_ack` is 1 for exactly the cycle in which the inverted bit is presented with `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One bit slot is offered this cycle |
| chan_idx | input | 5 | Time-slot number of the offered bit |
| chan_mask | input | 24 | Per-channel enable, bit i for channel i |
| pat_sel | input | 3 | Pattern family select |
| pat_word | input | 32 | Pattern register / LFSR seed |
| len_code | input | 4 | Repetitive length code (length = code + 17) |
| alt_count | input | 8 | Repeats of each word in alternating mode |
| load | input | 1 | Configuration load control, rising-edge active |
| err_strobe | input | 1 | Single-error request, rising-edge active |
| tx_bit | output | 1 | Generated data bit |
| tx_valid | output | 1 | `tx_bit` carries an enabled slot |
| err_ack | output | 1 | The presented bit was inverted |

## Verification
The assertions assume that `load` and `err_strobe` are plain level signals, sampled once per clock, and that configuration changes matter only at a load edge. Under that assumption, the held-configuration and index-range properties can rely on state that only a restart rewrites. The stimulus applies every input change half a cycle away from the clock edge, and it keeps error pulses and load pulses in cycles apart from enabled slots, except in the one directed case where a slot coincides with a load edge. Random phases draw the pattern, mask, slot numbers (including numbers beyond 23) and counts from a fixed seed, and the directed phases force long zero seeds, zero seeds and repeated error strobes.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int PAT_W       = 32;
    localparam int ALT_CNT_W   = 8;
    localparam int LEN_CODE_W  = 4;
    localparam int LFSR_W      = 20;
    localparam int QRSS_ZMAX   = 14;
    localparam int REP_BASE    = 17;

    typedef enum logic [2:0] {
        PAT_PRBS7   = 3'b000,
        PAT_PRBS11  = 3'b001,
        PAT_PRBS15  = 3'b010,
        PAT_QRSS    = 3'b011,
        PAT_REPEAT  = 3'b100,
        PAT_ALTWORD = 3'b101,
        PAT_OCTET55 = 3'b110,
        PAT_PRBS9   = 3'b111
    } pat_mode_e;

    typedef struct packed {
        pat_mode_e               mode;
        logic [PAT_W-1:0]        pattern;
        logic [LEN_CODE_W-1:0]   len_code;
        logic [ALT_CNT_W-1:0]    alt_count;
    } gen_cfg_t;

    function automatic logic is_lfsr(pat_mode_e m);
        return (m != PAT_REPEAT) && (m != PAT_ALTWORD) && (m != PAT_OCTET55);
    endfunction

    // Degree of the register for a mode; non-LFSR modes use the full width.
    function automatic logic [4:0] lfsr_deg(pat_mode_e m);
        case (m)
            PAT_PRBS7:  return 5'd7;
            PAT_PRBS9:  return 5'd9;
            PAT_PRBS11: return 5'd11;
            PAT_PRBS15: return 5'd15;
            default:    return 5'd20;
        endcase
    endfunction

    function automatic logic [4:0] lfsr_tap(pat_mode_e m);
        case (m)
            PAT_PRBS7:  return 5'd6;
            PAT_PRBS9:  return 5'd5;
            PAT_PRBS11: return 5'd9;
            PAT_PRBS15: return 5'd14;
            default:    return 5'd17;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_mask(pat_mode_e m);
        logic [LFSR_W-1:0] r;
        for (int i = 0; i < LFSR_W; i++) r[i] = (5'(i) < lfsr_deg(m));
        return r;
    endfunction

endpackage

// File: rtl/bert_cfg_shadow.sv
module bert_cfg_shadow
    import bert_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  gen_cfg_t cfg_in,
    output gen_cfg_t cfg_out,
    output logic     restart
);
    logic load_q;

    assign restart = load & ~load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q            <= 1'b0;
            cfg_out.mode      <= PAT_PRBS7;
            cfg_out.pattern   <= '1;
            cfg_out.len_code  <= '0;
            cfg_out.alt_count <= '0;
        end else begin
            load_q <= load;
            if (restart) cfg_out <= cfg_in;
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(cfg_out));

endmodule

// File: rtl/bert_lfsr_gen.sv
module bert_lfsr_gen
    import bert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  pat_mode_e         new_mode,
    input  logic [LFSR_W-1:0] new_seed,
    input  pat_mode_e         mode,
    input  logic              step,
    output logic              bit_o
);
    logic [LFSR_W-1:0] state;
    logic [3:0]        zrun;
    logic [LFSR_W-1:0] seed_m;
    logic [4:0]        deg;
    logic [4:0]        tap;
    logic              raw_bit;
    logic              force_one;

    assign seed_m    = new_seed & lfsr_mask(new_mode);
    assign deg       = lfsr_deg(mode);
    assign tap       = lfsr_tap(mode);
    assign raw_bit   = state[deg - 5'd1];
    assign force_one = (mode == PAT_QRSS) && (zrun == 4'(QRSS_ZMAX));
    assign bit_o     = raw_bit | force_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '1;
            zrun  <= '0;
        end else if (restart) begin
            state <= (seed_m == '0) ? lfsr_mask(new_mode) : seed_m;
            zrun  <= '0;
        end else if (step && is_lfsr(mode)) begin
            state <= {state[LFSR_W-2:0], state[deg - 5'd1] ^ state[tap - 5'd1]};
            zrun  <= bit_o ? 4'd0 : zrun + 4'd1;
        end
    end

    // R3
    qrss_run_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PAT_QRSS) |-> (zrun <= 4'(QRSS_ZMAX)));

    // R2
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        is_lfsr(mode) |-> ((state & lfsr_mask(mode)) != '0));

endmodule

// File: rtl/bert_word_gen.sv
module bert_word_gen
    import bert_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  gen_cfg_t cfg,
    input  logic     step,
    output logic     bit_o
);
    logic [4:0]           idx;
    logic [ALT_CNT_W-1:0] rep_cnt;
    logic                 word_hi;
    logic [4:0]           rep_last;
    logic [ALT_CNT_W-1:0] alt_target;

    assign rep_last   = 5'(cfg.len_code) + 5'(REP_BASE - 1);
    assign alt_target = (cfg.alt_count == '0) ? ALT_CNT_W'(1) : cfg.alt_count;

    always_comb begin
        case (cfg.mode)
            PAT_REPEAT:  bit_o = cfg.pattern[idx];
            PAT_ALTWORD: bit_o = cfg.pattern[{word_hi, idx[3:0]}];
            default:     bit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx     <= '0;
            rep_cnt <= '0;
            word_hi <= 1'b0;
        end else if (step) begin
            if (cfg.mode == PAT_REPEAT) begin
                idx <= (idx == rep_last) ? 5'd0 : idx + 5'd1;
            end else if (cfg.mode == PAT_ALTWORD) begin
                if (idx[3:0] == 4'hF) begin
                    idx <= '0;
                    if (rep_cnt == alt_target - ALT_CNT_W'(1)) begin
                        rep_cnt <= '0;
                        word_hi <= ~word_hi;
                    end else begin
                        rep_cnt <= rep_cnt + ALT_CNT_W'(1);
                    end
                end else begin
                    idx <= idx + 5'd1;
                end
            end
        end
    end

    // R4
    rep_index_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PAT_REPEAT) |-> (idx <= rep_last));

    // R5
    alt_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PAT_ALTWORD) |-> (rep_cnt < alt_target && idx < 5'd16));

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_tick,
    input  logic [CH_IDX_W-1:0]   chan_idx,
    input  logic [CHANNELS-1:0]   chan_mask,
    input  logic [2:0]            pat_sel,
    input  logic [PAT_W-1:0]      pat_word,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic [ALT_CNT_W-1:0]  alt_count,
    input  logic                  load,
    input  logic                  err_strobe,
    output logic                  tx_bit,
    output logic                  tx_valid,
    output logic                  err_ack
);
    localparam int IDX_SPAN = 2 ** CH_IDX_W;

    gen_cfg_t              cfg_in;
    gen_cfg_t              cfg;
    logic                  restart;
    logic [IDX_SPAN-1:0]   mask_ext;
    logic                  advance;
    logic                  lfsr_bit;
    logic                  word_bit;
    logic                  pat_bit;
    logic                  err_q;
    logic                  err_pend;
    logic                  err_rise;

    assign cfg_in.mode      = pat_mode_e'(pat_sel);
    assign cfg_in.pattern   = pat_word;
    assign cfg_in.len_code  = len_code;
    assign cfg_in.alt_count = alt_count;

    assign mask_ext = IDX_SPAN'(chan_mask);
    assign advance  = bit_tick && mask_ext[chan_idx] && !restart;
    assign err_rise = err_strobe && !err_q;

    bert_cfg_shadow i_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_in),
        .cfg_out (cfg),
        .restart (restart)
    );

    bert_lfsr_gen i_lfsr (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .new_mode (cfg_in.mode),
        .new_seed (pat_word[LFSR_W-1:0]),
        .mode     (cfg.mode),
        .step     (advance),
        .bit_o    (lfsr_bit)
    );

    bert_word_gen i_word (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cfg     (cfg),
        .step    (advance),
        .bit_o   (word_bit)
    );

    always_comb begin
        if (cfg.mode == PAT_OCTET55)   pat_bit = 1'b1;
        else if (is_lfsr(cfg.mode))    pat_bit = lfsr_bit;
        else                           pat_bit = word_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q    <= 1'b0;
            err_pend <= 1'b0;
            tx_valid <= 1'b0;
            tx_bit   <= 1'b0;
            err_ack  <= 1'b0;
        end else begin
            err_q    <= err_strobe;
            err_pend <= err_rise | (err_pend & ~advance);
            tx_valid <= advance;
            tx_bit   <= advance & (pat_bit ^ err_pend);
            err_ack  <= advance & err_pend;
        end
    end

    // R9
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bit_tick));

    // R8
    masked_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !mask_ext[chan_idx]) |=> !tx_valid);

    // R11
    ack_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
        err_ack |-> tx_valid);

    // R9
    idle_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> !tx_bit);

endmodule

// File: tb/test_bert_patgen.sv
module test_bert_patgen;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick;
    logic [4:0]  chan_idx;
    logic [23:0] chan_mask;
    logic [2:0]  pat_sel;
    logic [31:0] pat_word;
    logic [3:0]  len_code;
    logic [7:0]  alt_count;
    logic        load;
    logic        err_strobe;
    logic        tx_bit;
    logic        tx_valid;
    logic        err_ack;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model state
    int          m_sel;
    logic [31:0] m_pat;
    int          m_len;
    int          m_cnt;
    logic [19:0] m_lfsr;
    int          m_zrun;
    int          m_idx;
    int          m_rep;
    int          m_word;
    bit          m_pend;
    int          zero_run;
    int          max_zero_run;

    always #10 clk = ~clk;

    bert_patgen i_bert_patgen (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .chan_idx(chan_idx),
        .chan_mask(chan_mask), .pat_sel(pat_sel), .pat_word(pat_word),
        .len_code(len_code), .alt_count(alt_count), .load(load),
        .err_strobe(err_strobe), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .err_ack(err_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int deg_of(int s);
        case (s)
            0: return 7;  7: return 9;  1: return 11;  2: return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int tap_of(int s);
        case (s)
            0: return 6;  7: return 5;  1: return 9;  2: return 14;
            default: return 17;
        endcase
    endfunction

    function automatic logic [19:0] mask_of(int s);
        return 20'((64'd1 << deg_of(s)) - 64'd1);
    endfunction

    function automatic bit is_prbs(int s);
        return (s <= 3) || (s == 7);
    endfunction

    function automatic bit m_bit();
        case (m_sel)
            3: return (m_zrun == 14) ? 1'b1 : m_lfsr[19];
            4: return m_pat[m_idx];
            5: return m_pat[m_word * 16 + m_idx];
            6: return 1'b1;
            default: return m_lfsr[deg_of(m_sel) - 1];
        endcase
    endfunction

    task automatic m_advance();
        bit b;
        int target;
        b = m_bit();
        if (is_prbs(m_sel)) begin
            m_lfsr = {m_lfsr[18:0], m_lfsr[deg_of(m_sel)-1] ^ m_lfsr[tap_of(m_sel)-1]};
            if (m_sel == 3) m_zrun = b ? 0 : m_zrun + 1;
        end else if (m_sel == 4) begin
            m_idx = (m_idx == m_len + 16) ? 0 : m_idx + 1;
        end else if (m_sel == 5) begin
            target = (m_cnt == 0) ? 1 : m_cnt;
            if (m_idx == 15) begin
                m_idx = 0;
                m_rep++;
                if (m_rep >= target) begin
                    m_rep  = 0;
                    m_word = 1 - m_word;
                end
            end else m_idx++;
        end
    endtask

    task automatic m_restart(input int s, input logic [31:0] p, input int l, input int c);
        m_sel = s; m_pat = p; m_len = l; m_cnt = c;
        m_lfsr = p[19:0] & mask_of(s);
        if (m_lfsr == 20'd0) m_lfsr = mask_of(s);
        m_zrun = 0; m_idx = 0; m_rep = 0; m_word = 0;
    endtask

    task automatic do_load(input int s, input logic [31:0] p, input int l, input int c);
        @(negedge clk);
        pat_sel = 3'(s); pat_word = p; len_code = 4'(l); alt_count = 8'(c);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_restart(s, p, l, c);
    endtask

    task automatic pulse_err();
        @(negedge clk);
        err_strobe = 1'b1;
        @(negedge clk);
        err_strobe = 1'b0;
        m_pend = 1'b1;
    endtask

    task automatic send_slot(input int ch, input string req);
        bit en, exp_bit, exp_ack;
        @(negedge clk);
        bit_tick = 1'b1;
        chan_idx = 5'(ch);
        en = (ch < 24) && chan_mask[ch];
        exp_bit = 1'b0; exp_ack = 1'b0;
        if (en) begin
            exp_bit = m_bit() ^ m_pend;
            exp_ack = m_pend;
            m_pend  = 1'b0;
            m_advance();
        end
        @(negedge clk);
        bit_tick = 1'b0;
        check(tx_valid == en, {req, " valid"}, int'(tx_valid), int'(en));
        check(tx_bit == exp_bit, {req, " bit"}, int'(tx_bit), int'(exp_bit));
        check(err_ack == exp_ack, {req, " ack"}, int'(err_ack), int'(exp_ack));
        if (en && !exp_ack) begin
            zero_run = tx_bit ? 0 : zero_run + 1;
            if (zero_run > max_zero_run) max_zero_run = zero_run;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bit_tick = 0; chan_idx = 0; chan_mask = '1; pat_sel = 3'd4;
        pat_word = 32'h1234_5678; len_code = 4'd3; alt_count = 8'd2;
        load = 0; err_strobe = 0; m_pend = 0; zero_run = 0; max_zero_run = 0;
        repeat (4) @(negedge clk);
        check(tx_valid == 0 && tx_bit == 0 && err_ack == 0, "R1 reset outputs",
              int'({tx_valid, tx_bit, err_ack}), 0);
        rst = 1'b0;
        m_restart(0, 32'hFFFF_FFFF, 0, 0);
        m_lfsr = 20'hFFFFF;
        // R1: power-up PRBS7 from all ones, no load yet
        for (int i = 0; i < 40; i++) send_slot(i % 24, "R1 power-up prbs7");
        // R9: valid lasts one cycle
        @(negedge clk);
        check(tx_valid == 0, "R9 single-cycle valid", int'(tx_valid), 0);

        // R2: each PRBS degree, with a zero seed for PRBS11
        do_load(7, 32'hFFFF_FFFF, 0, 0);
        for (int i = 0; i < 600; i++) send_slot(i % 24, "R2 prbs9");
        do_load(1, 32'h0000_0000, 0, 0);
        for (int i = 0; i < 300; i++) send_slot(i % 24, "R2 prbs11 zero seed");
        do_load(2, 32'hFFFF_FFFF, 0, 0);
        for (int i = 0; i < 300; i++) send_slot(i % 24, "R2 prbs15");

        // R3: QRSS seeded so a long zero run appears at once
        zero_run = 0; max_zero_run = 0;
        do_load(3, 32'h0000_0001, 0, 0);
        for (int i = 0; i < 1500; i++) send_slot(i % 24, "R3 qrss");
        check(max_zero_run <= 14, "R3 zero run limit", max_zero_run, 14);
        check(max_zero_run == 14, "R3 forced one after 14 zeros", max_zero_run, 14);

        // R4: shortest and longest repetitive lengths
        do_load(4, 32'h0001_A5C3, 0, 0);
        for (int i = 0; i < 60; i++) send_slot(i % 24, "R4 repeat len17");
        do_load(4, 32'h8F00_3C71, 15, 0);
        for (int i = 0; i < 70; i++) send_slot(i % 24, "R4 repeat len32");

        // R5: alternating words, count 0 and count 3
        do_load(5, 32'hF0F0_1234, 0, 0);
        for (int i = 0; i < 70; i++) send_slot(i % 24, "R5 altword count0");
        do_load(5, 32'hA5A5_00FF, 0, 3);
        for (int i = 0; i < 200; i++) send_slot(i % 24, "R5 altword count3");

        // R6: 55-octet stand-in is all ones
        do_load(6, 32'h0, 0, 0);
        for (int i = 0; i < 30; i++) send_slot(i % 24, "R6 all ones");

        // R7: configuration change without a load edge is ignored
        do_load(4, 32'h0F0F_3355, 5, 0);
        for (int i = 0; i < 10; i++) send_slot(i % 24, "R7 before change");
        @(negedge clk);
        pat_sel = 3'd6; pat_word = 32'h0; len_code = 4'd9;
        for (int i = 0; i < 30; i++) send_slot(i % 24, "R7 ignored change");
        // R7: slot coinciding with the load edge gives no output
        @(negedge clk);
        pat_sel = 3'd0; pat_word = 32'hFFFF_FFFF; load = 1'b1; bit_tick = 1'b1; chan_idx = 5'd0;
        @(negedge clk);
        load = 1'b0; bit_tick = 1'b0;
        check(tx_valid == 0, "R7 load-edge slot quiet", int'(tx_valid), 0);
        m_restart(0, 32'hFFFF_FFFF, 0, 0);
        for (int i = 0; i < 20; i++) send_slot(i % 24, "R7 restart after load");

        // R8: masked and out-of-range slots do not advance
        chan_mask = 24'h00_0F0F;
        for (int i = 0; i < 64; i++) send_slot(i % 32, "R8 channel gating");
        chan_mask = '1;

        // R10 / R11: single insertion, repeated strobes insert once
        pulse_err();
        send_slot(3, "R10 inverted bit");
        send_slot(4, "R11 no ack after");
        pulse_err(); pulse_err();
        send_slot(5, "R10 double strobe first");
        send_slot(6, "R10 double strobe second");
        chan_mask = 24'h00_0001;
        pulse_err();
        send_slot(7, "R10 masked slot keeps arm");
        send_slot(0, "R11 ack on enabled slot");
        chan_mask = '1;

        // random phases
        for (int ph = 0; ph < 8; ph++) begin
            int s;
            logic [31:0] p;
            s = int'($urandom_range(7));
            p = (is_prbs(s) && $urandom_range(1) == 0) ? 32'hFFFF_FFFF : $urandom();
            chan_mask = 24'($urandom()) | 24'h1;
            do_load(s, p, int'($urandom_range(15)), int'($urandom_range(3)));
            for (int i = 0; i < 250; i++) begin
                if ($urandom_range(19) == 0) pulse_err();
                send_slot(int'($urandom_range(27)), "R8 R10 random mix");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule